// File: doc/BRIEF.md
# Debugger Message Mailbox

This block carries short messages in both directions between an external JTAG debugger and the on-chip CPU. On the debugger side it sees the TAP controller's state strobes (instruction update, data capture, data shift, data update), each one clock cycle wide and synchronous to the block clock. It also sees the fields of the current instruction: an operation (receive or transmit), a 4-bit message ID and a length code. Its own data scan register changes length per scan, from 8 to 40 bits in steps of 8. On the CPU side a simple register bus reads the received message and its status. The CPU loads the outgoing message, sets the length the debugger must scan, requests a transmit interrupt, owns a lock register, and acknowledges the interrupt source bits.

A receive scan places the shifted data into the receive buffer, marks the link busy and raises the source bit of its ID. The CPU then reads the buffer and releases the link. ID 1111 is reserved: a receive instruction that carries it is an abort. The abort skips the busy handshake, raises the abort source bits selected by the mask register as soon as the instruction is updated, and is accepted while the link is busy. A transmit scan loads the outgoing buffer into the scan register at capture. At data update it fills the lock register with ones and drops the transmit interrupt, which frees the link.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset every CPU-readable register reads zero, and `dbg_irq` and `tx_irq` are low.
- R2: A receive data update with an ID other than 1111 and the link not busy copies the scanned bits into the receive buffer. The buffer reads at address 0 (bits 31:0) and address 1 (bits 39:32). Receive status at address 2 then shows busy in bit 8, the ID in bits 7:4 and the length code in bits 2:0.
- R3: Such a receive sets source bit ID (bits 15:0 of address 7) and raises `dbg_irq`.
- R4: A receive data update while the link is busy is dropped: buffer, status and source bits are unchanged.
- R5: A CPU write to address 2 with bit 8 set clears busy. Source bits at address 7 are cleared by writing ones.
- R6: A receive instruction update with ID 1111 sets abort source bits 31:16 of address 7 wherever mask bits 15:0 (address 8) are set. It leaves busy and the receive status unchanged, even when busy is set.
- R7: The abort source bits and `dbg_irq` are visible in the cycle right after the instruction-update strobe.
- R8: Length code c selects 8*(c+1) scan bits for c = 0..4; codes 5 to 7 select 40 bits. Data shifts in at `tdi` and out at `tdo`, least significant bit first.
- R9: A transmit capture loads the transmit buffer (address 3 low word, address 4 high bits) into the scan register. The scan length comes from the length code in bits 2:0 of transmit status (address 5).
- R10: A CPU write to address 5 with bit 8 set raises `tx_irq`, read back in bit 8. A transmit data update sets the lock register (address 6, 8 bits) to all ones and clears `tx_irq`.
- R11: A transmit data update leaves the transmit buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tap_ir_upd | input | 1 | instruction update strobe |
| tap_dr_cap | input | 1 | data capture strobe |
| tap_dr_sh | input | 1 | data shift strobe, one bit per cycle |
| tap_dr_upd | input | 1 | data update strobe |
| ir_op | input | 2 | operation at instruction update: 1 receive, 2 transmit, else none |
| ir_id | input | 4 | message ID at instruction update |
| ir_len | input | 3 | receive length code at instruction update |
| tdi | input | 1 | serial data in |
| tdo | output | 1 | serial data out |
| cpu_addr | input | 4 | register address |
| cpu_wr | input | 1 | write strobe |
| cpu_wdata | input | 32 | write data |
| cpu_rdata | output | 32 | read data, combinational from address |
| dbg_irq | output | 1 | any receive or abort source bit set |
| tx_irq | output | 1 | transmit interrupt |

## Verification
The bench uses the default parameters: an 8-bit length step, five length settings and a 4-bit ID. With these values the 40-bit maximum crosses the 32-bit CPU word, so the high-word buffer paths are exercised. The clamped length codes 5 to 7 can also be reached. The reserved ID 1111 falls inside a 16-bit source field, which lets the bench check abort masking against every receive source bit.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RECV = 2'd1, OP_SEND = 2'd2, OP_RSVD = 2'd3} op_e;

  // number of scan bits for a length code; codes past the last setting clamp
  function automatic int unsigned scan_bits(input logic [2:0] code, input int unsigned step,
                                            input int unsigned nset);
    int unsigned idx;
    idx = (int'(code) >= nset) ? nset : int'(code) + 1;
    return idx * step;
  endfunction
endpackage

// File: rtl/dbg_scan_reg.sv
module dbg_scan_reg #(
  parameter int DATA_W = 40,
  parameter int LB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_val,
  input  logic              sh,
  input  logic              tdi,
  input  logic [LB_W-1:0]   len,
  output logic [DATA_W-1:0] sr,
  output logic              tdo
);
  logic [DATA_W-1:0] nxt_shift;
  logic [DATA_W-1:0] len_mask;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      len_mask[i] = (i < int'(len));
      if (i + 1 < int'(len))       nxt_shift[i] = sr[i+1];
      else if (i + 1 == int'(len)) nxt_shift[i] = tdi;
      else                         nxt_shift[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sr <= '0;
    else if (cap && cap_en) sr <= cap_val & len_mask;
    else if (sh)           sr <= nxt_shift;
  end

  assign tdo = sr[0];

  // R8: a shift places tdi at the top bit of the selected length
  p_shift_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sh && !cap && len != '0) |=> sr[$past(len) - 1'b1] == $past(tdi));
endmodule

// File: rtl/dbg_rx_side.sv
module dbg_rx_side #(
  parameter int DATA_W = 40,
  parameter int ID_W   = 4,
  parameter int NID    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [ID_W-1:0]   id,
  input  logic [2:0]        lenc,
  input  logic              abort,
  input  logic [NID-1:0]    mask,
  input  logic              clr_busy,
  input  logic [NID-1:0]    rx_w1c,
  input  logic [NID-1:0]    ab_w1c,
  output logic [DATA_W-1:0] rxd,
  output logic              busy,
  output logic [ID_W-1:0]   st_id,
  output logic [2:0]        st_len,
  output logic [NID-1:0]    rx_src,
  output logic [NID-1:0]    ab_src,
  output logic              ev_rx_load
);
  assign ev_rx_load = load && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd    <= '0;
      busy   <= 1'b0;
      st_id  <= '0;
      st_len <= '0;
    end else if (ev_rx_load) begin
      rxd    <= data;
      busy   <= 1'b1;
      st_id  <= id;
      st_len <= lenc;
    end else if (clr_busy) begin
      busy <= 1'b0;
    end
  end

  for (genvar g = 0; g < NID; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_src[g] <= 1'b0;
        ab_src[g] <= 1'b0;
      end else begin
        if (ev_rx_load && id == ID_W'(g)) rx_src[g] <= 1'b1;
        else if (rx_w1c[g])                rx_src[g] <= 1'b0;
        if (abort && mask[g])              ab_src[g] <= 1'b1;
        else if (ab_w1c[g])                ab_src[g] <= 1'b0;
      end
    end
  end

  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_load |=> busy && rxd == $past(data));
  p_src_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_load |=> rx_src[$past(id)]);
  p_drop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> $stable(rxd) && $stable(st_id) && $stable(st_len));
  p_abort_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !load && !clr_busy) |=> $stable(busy) && $stable(st_id));
  p_abort_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (ab_src & $past(mask)) == $past(mask));
endmodule

// File: rtl/dbg_tx_side.sv
module dbg_tx_side #(
  parameter int DATA_W = 40,
  parameter int CPU_W  = 32,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_st,
  input  logic              wr_lock,
  input  logic [CPU_W-1:0]  wdata,
  input  logic              tx_done,
  output logic [DATA_W-1:0] txd,
  output logic [2:0]        tx_lenc,
  output logic              tint,
  output logic [LOCK_W-1:0] lock
);
  localparam int HI_W = DATA_W - CPU_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd     <= '0;
      tx_lenc <= '0;
    end else begin
      if (wr_lo) txd[CPU_W-1:0]      <= wdata;
      if (wr_hi) txd[DATA_W-1:CPU_W] <= wdata[HI_W-1:0];
      if (wr_st) tx_lenc             <= wdata[2:0];
    end
  end

  // debugger side wins over a CPU write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tint <= 1'b0;
      lock <= '0;
    end else if (tx_done) begin
      tint <= 1'b0;
      lock <= '1;
    end else begin
      if (wr_st && wdata[8]) tint <= 1'b1;
      if (wr_lock)           lock <= wdata[LOCK_W-1:0];
    end
  end

  p_done_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> lock == '1 && !tint);
  p_done_keeps_buf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !wr_lo && !wr_hi) |=> $stable(txd));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mailbox_pkg::*;
#(
  parameter int LEN_STEP = 8,
  parameter int NUM_LEN  = 5,
  parameter int ID_W     = 4,
  parameter int CPU_W    = 32,
  parameter int LOCK_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tap_ir_upd,
  input  logic        tap_dr_cap,
  input  logic        tap_dr_sh,
  input  logic        tap_dr_upd,
  input  logic [1:0]  ir_op,
  input  logic [3:0]  ir_id,
  input  logic [2:0]  ir_len,
  input  logic        tdi,
  output logic        tdo,
  input  logic [3:0]  cpu_addr,
  input  logic        cpu_wr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        dbg_irq,
  output logic        tx_irq
);
  localparam int DATA_W = LEN_STEP * NUM_LEN;
  localparam int LB_W   = $clog2(DATA_W + 1);
  localparam int NID    = 1 << ID_W;
  localparam int HI_W   = DATA_W - CPU_W;
  localparam logic [3:0] A_RXD_LO = 4'd0, A_RXD_HI = 4'd1, A_RXST = 4'd2,
                         A_TXD_LO = 4'd3, A_TXD_HI = 4'd4, A_TXST = 4'd5,
                         A_LOCK   = 4'd6, A_SRC    = 4'd7, A_MASK = 4'd8;

  // active instruction
  op_e             op_q;
  logic [ID_W-1:0] id_q;
  logic [2:0]      len_q;
  logic [NID-1:0]  mask_q;

  logic ev_abort, ev_rx_upd, ev_tx_done, ev_rx_load;
  logic [ID_W-1:0] id_abort;
  assign id_abort   = '1;
  assign ev_abort   = tap_ir_upd && op_e'(ir_op) == OP_RECV && ir_id[ID_W-1:0] == id_abort;
  assign ev_rx_upd  = tap_dr_upd && op_q == OP_RECV && id_q != id_abort;
  assign ev_tx_done = tap_dr_upd && op_q == OP_SEND;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      id_q   <= '0;
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      if (tap_ir_upd) begin
        op_q  <= op_e'(ir_op);
        id_q  <= ir_id[ID_W-1:0];
        len_q <= ir_len;
      end
      if (cpu_wr && cpu_addr == A_MASK) mask_q <= cpu_wdata[NID-1:0];
    end
  end

  // scan length selection
  logic [2:0]        tx_lenc;
  logic [2:0]        cur_lenc;
  logic [LB_W-1:0]   cur_len;
  logic [DATA_W-1:0] sr, txd, rxd;
  assign cur_lenc = (op_q == OP_SEND) ? tx_lenc : len_q;
  assign cur_len  = LB_W'(scan_bits(cur_lenc, LEN_STEP, NUM_LEN));

  dbg_scan_reg #(.DATA_W(DATA_W), .LB_W(LB_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .cap(tap_dr_cap), .cap_en(op_q == OP_SEND),
    .cap_val(txd), .sh(tap_dr_sh), .tdi(tdi), .len(cur_len), .sr(sr), .tdo(tdo));

  logic              busy;
  logic [ID_W-1:0]   st_id;
  logic [2:0]        st_len;
  logic [NID-1:0]    rx_src, ab_src;
  logic              wr_src;
  assign wr_src = cpu_wr && cpu_addr == A_SRC;

  dbg_rx_side #(.DATA_W(DATA_W), .ID_W(ID_W), .NID(NID)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(ev_rx_upd), .data(sr), .id(id_q), .lenc(len_q),
    .abort(ev_abort), .mask(mask_q),
    .clr_busy(cpu_wr && cpu_addr == A_RXST && cpu_wdata[8]),
    .rx_w1c(wr_src ? cpu_wdata[NID-1:0] : '0),
    .ab_w1c(wr_src ? cpu_wdata[2*NID-1:NID] : '0),
    .rxd(rxd), .busy(busy), .st_id(st_id), .st_len(st_len),
    .rx_src(rx_src), .ab_src(ab_src), .ev_rx_load(ev_rx_load));

  logic              tint;
  logic [LOCK_W-1:0] lock;

  dbg_tx_side #(.DATA_W(DATA_W), .CPU_W(CPU_W), .LOCK_W(LOCK_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(cpu_wr && cpu_addr == A_TXD_LO), .wr_hi(cpu_wr && cpu_addr == A_TXD_HI),
    .wr_st(cpu_wr && cpu_addr == A_TXST), .wr_lock(cpu_wr && cpu_addr == A_LOCK),
    .wdata(cpu_wdata), .tx_done(ev_tx_done),
    .txd(txd), .tx_lenc(tx_lenc), .tint(tint), .lock(lock));

  assign dbg_irq = |{rx_src, ab_src};
  assign tx_irq  = tint;

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_RXD_LO: cpu_rdata = rxd[CPU_W-1:0];
      A_RXD_HI: cpu_rdata[HI_W-1:0] = rxd[DATA_W-1:CPU_W];
      A_RXST:   cpu_rdata = {23'd0, busy, (4)'(st_id), 1'b0, st_len};
      A_TXD_LO: cpu_rdata = txd[CPU_W-1:0];
      A_TXD_HI: cpu_rdata[HI_W-1:0] = txd[DATA_W-1:CPU_W];
      A_TXST:   cpu_rdata = {23'd0, tint, 5'd0, tx_lenc};
      A_LOCK:   cpu_rdata[LOCK_W-1:0] = lock;
      A_SRC:    cpu_rdata[2*NID-1:0] = {ab_src, rx_src};
      A_MASK:   cpu_rdata[NID-1:0] = mask_q;
      default:  cpu_rdata = '0;
    endcase
  end

  p_abort_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && mask_q != '0) |=> dbg_irq);
  p_abort_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_dr_upd && op_q == OP_RECV && id_q == id_abort) |-> !ev_rx_load);
endmodule

// File: tb/sim_dbg_mailbox.sv
module sim_dbg_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tap_ir_upd = 0, tap_dr_cap = 0, tap_dr_sh = 0, tap_dr_upd = 0, tdi = 0;
  logic [1:0] ir_op = 0;
  logic [3:0] ir_id = 0;
  logic [2:0] ir_len = 0;
  logic [3:0] cpu_addr = 0;
  logic cpu_wr = 0;
  logic [31:0] cpu_wdata = 0;
  logic tdo, dbg_irq, tx_irq;
  logic [31:0] cpu_rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbg_mailbox u0 (.*);

  function automatic int nbits(input int code);
    case (code)
      0: return 8; 1: return 16; 2: return 24; 3: return 32;
      default: return 40;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); cpu_addr = a; #1 v = cpu_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic ir(input logic [1:0] op, input logic [3:0] id, input logic [2:0] lc);
    @(negedge clk); ir_op = op; ir_id = id; ir_len = lc; tap_ir_upd = 1;
    @(negedge clk); tap_ir_upd = 0;
  endtask

  task automatic dr(input int len, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    @(negedge clk); tap_dr_cap = 1;
    @(negedge clk); tap_dr_cap = 0;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo; tdi = din[i]; tap_dr_sh = 1;
      @(negedge clk);
    end
    tap_dr_sh = 0; tdi = 0; tap_dr_upd = 1;
    @(negedge clk); tap_dr_upd = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 dbg_irq", dbg_irq, 0); chk("R1 tx_irq", tx_irq, 0);
  endtask

  task automatic t_rx_basic();
    logic [31:0] v; logic [39:0] o;
    ir(2'd1, 4'd3, 3'd1);
    dr(nbits(1), 40'hFF_1234_A5C3, o);
    rd(4'd0, v); chk("R2 rxd lo", v, 32'h0000_A5C3);
    rd(4'd1, v); chk("R2 rxd hi", v, 0);
    rd(4'd2, v); chk("R2 rxst", v, 32'h0000_0131);
    rd(4'd7, v); chk("R3 src", v, 32'h0000_0008);
    chk("R3 dbg_irq", dbg_irq, 1);
  endtask

  task automatic t_rx_drop();
    logic [31:0] v; logic [39:0] o;
    ir(2'd1, 4'd5, 3'd0);
    dr(8, 40'h77, o);
    rd(4'd0, v); chk("R4 rxd kept", v, 32'h0000_A5C3);
    rd(4'd2, v); chk("R4 rxst kept", v, 32'h0000_0131);
    rd(4'd7, v); chk("R4 src kept", v, 32'h0000_0008);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(4'd8, 32'h0000_8005);
    @(negedge clk); ir_op = 2'd1; ir_id = 4'hF; ir_len = 0; tap_ir_upd = 1;
    @(negedge clk); tap_ir_upd = 0;
    chk("R7 irq next cycle", dbg_irq, 1);
    cpu_addr = 4'd7; #1 chk("R7 abort src", cpu_rdata, 32'h8005_0008);
    rd(4'd2, v); chk("R6 busy kept", v, 32'h0000_0131);
  endtask

  task automatic t_release();
    logic [31:0] v;
    wr(4'd2, 32'h100);
    rd(4'd2, v); chk("R5 busy clr", v[8], 0);
    wr(4'd7, 32'h8005_0008);
    rd(4'd7, v); chk("R5 src w1c", v, 0);
    chk("R5 irq low", dbg_irq, 0);
  endtask

  task automatic t_rx_clamp();
    logic [31:0] v; logic [39:0] o;
    ir(2'd1, 4'd9, 3'd7);
    dr(40, 40'hC3_8765_4321, o);
    rd(4'd0, v); chk("R8 clamp lo", v, 32'h8765_4321);
    rd(4'd1, v); chk("R8 clamp hi", v, 32'h0000_00C3);
    rd(4'd7, v); chk("R3 src id9", v, 32'h0000_0200);
    wr(4'd2, 32'h100); wr(4'd7, 32'h200);
  endtask

  task automatic t_tx(input int lc, input logic [39:0] d);
    logic [31:0] v; logic [39:0] o, m;
    m = (40'd1 << nbits(lc)) - 1;
    wr(4'd3, d[31:0]); wr(4'd4, {24'd0, d[39:32]});
    wr(4'd6, 32'h5A);
    wr(4'd5, 32'h100 | 32'(lc));
    chk("R10 tx_irq set", tx_irq, 1);
    ir(2'd2, 4'd0, 3'd0);
    dr(nbits(lc), 40'hFF_FFFF_FFFF, o);
    chk("R9 tdo stream", o, d & m);
    rd(4'd6, v); chk("R10 lock", v, 32'hFF);
    rd(4'd5, v); chk("R10 tint clr", v, 32'(lc));
    chk("R10 tx_irq low", tx_irq, 0);
    rd(4'd3, v); chk("R11 txd lo", v, d[31:0]);
    rd(4'd4, v); chk("R11 txd hi", v, {24'd0, d[39:32]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rx_basic();
    t_rx_drop();
    t_abort();
    t_release();
    t_rx_clamp();
    t_tx(4, 40'h9E_1234_5678);
    t_tx(0, 40'h12_3456_78B4);
    t_tx(2, 40'h00_00AB_CDEF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule